// File: doc/BRIEF.md
# Parallel-Chain Execute Packet Dispatcher

This block sits between the instruction fetch stage and the decoders of a wide-issue core. It accepts one 256-bit fetch packet at a time over a valid/ready handshake. The packet holds eight 32-bit instruction slots. The block breaks the packet into execute packets and issues one execute packet per cycle on an eight-lane output.

The boundaries between execute packets come from a chain bit held in each slot. Slots are scanned upward from slot 0. A set chain bit joins the next slot to the current group, and a clear bit closes the group. Each issued group comes with a lane-valid mask and the index of its lowest slot. Lane j always carries slot j. One group may therefore hold anywhere from one to eight instructions.

A downstream stall freezes issue without losing state. The block also reports how many issue cycles each fetch packet needed, in the same cycle as its last group.

Top module: `vliw_ep_dispatch`

## Requirements
- R1: A synchronous reset, sampled high at a rising edge, leaves the block idle after that edge. All `ep_lane_valid` bits are low, `fp_done` is low and `fp_ready` is high.
- R2: When idle, `fp_ready` is high. A fetch packet is taken at a rising edge where `fp_valid` and `fp_ready` are both high. Its first execute packet is presented in the following cycle, starting at slot 0. Slot k occupies bits [32k+31:32k] of `fp_data`.
- R3: The chain bit of slot k is bit 0 of that slot. An execute packet that starts at slot s covers slots s through e. Here e is the first slot at or above s whose chain bit is clear, or slot 7 if there is none. `ep_lane_valid` has exactly bits s..e set.
- R4: `ep_first_slot` gives the lowest slot of the issued group. The group issued in the next unstalled cycle starts at e+1.
- R5: The chain bit of slot 7 has no effect. A group never continues into the following fetch packet, and the next packet starts again at slot 0 with its own grouping.
- R6: `ep_lane_insn` lane k carries slot k of the held packet when lane k is valid. It is zero otherwise.
- R7: A packet needs one issue cycle per group. That is 1 plus the number of clear chain bits among slots 0..6: eight cycles with all bits clear, one cycle with all bits set.
- R8: `fp_ready` is low while a packet is being issued. It is high in the cycle its final group issues, so a packet offered then is taken without a gap, and its first group follows in the next cycle.
- R9: While `stall` is high, all lane-valid bits are low and `fp_done` is low. A busy block keeps `fp_ready` low and does not advance. The same group is issued once `stall` falls.
- R10: `fp_done` is high for exactly the cycle in which a packet's final group issues. In that cycle `fp_cycles` gives the number of groups issued for that packet.
- R11: A reset during issue discards the partly issued packet. The next packet accepted starts at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fp_valid | input | 1 | Fetch packet offered |
| fp_data | input | 256 | Fetch packet, slot 0 in the low 32 bits |
| fp_ready | output | 1 | Fetch packet can be taken this cycle |
| stall | input | 1 | Downstream hold, freezes issue |
| ep_lane_valid | output | 8 | Lanes issued this cycle |
| ep_lane_insn | output | 256 | Lane k carries slot k, zero when lane is not valid |
| ep_first_slot | output | 3 | Lowest slot of the issued group |
| fp_done | output | 1 | Final group of the packet issues this cycle |
| fp_cycles | output | 4 | Issue cycles taken by the finishing packet |

## Verification
All issue outputs are combinational from the held state and the current `stall`. They change one rising edge after the handshake or the previous issue. The bench therefore drives `stall` and `fp_valid` at the falling edge and samples every output 1 ns later, before the next rising edge. The first group of a packet is expected in the cycle after the edge that accepted it. Each later group is expected one unstalled cycle after the one before. `fp_done` and `fp_cycles` are compared in the same cycle as the final group.

// File: rtl/vliw_disp_pkg.sv
package vliw_disp_pkg;

  parameter int NSLOT = 8;

  // Lanes covered by the group that starts at slot 'start'.
  function automatic logic [NSLOT-1:0] ep_span(input logic [NSLOT-1:0] chain,
                                               input int start);
    logic run;
    ep_span = '0;
    run     = 1'b1;
    for (int j = 0; j < NSLOT; j++) begin
      if (j >= start && run) begin
        ep_span[j] = 1'b1;
        if (!chain[j]) run = 1'b0;
      end
    end
  endfunction

  function automatic int ep_width(input logic [NSLOT-1:0] mask);
    ep_width = $countones(mask);
  endfunction

endpackage

// File: rtl/vliw_ep_scan.sv
module vliw_ep_scan
  import vliw_disp_pkg::*;
#(
  parameter int SLOTS = NSLOT,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0] chain,
  input  logic [IDX_W-1:0] start,
  output logic [SLOTS-1:0] mask,
  output logic             last_grp,
  output logic [IDX_W-1:0] next_start
);
  int nxt;

  always_comb begin
    mask       = ep_span(chain, int'(start));
    last_grp   = mask[SLOTS-1];
    nxt        = int'(start) + ep_width(mask);
    next_start = IDX_W'(nxt);
  end
endmodule

// File: rtl/vliw_ep_lanes.sv
module vliw_ep_lanes #(
  parameter int SLOTS  = 8,
  parameter int SLOT_W = 32
) (
  input  logic [SLOTS*SLOT_W-1:0] pkt,
  input  logic [SLOTS-1:0]        lane_en,
  output logic [SLOTS*SLOT_W-1:0] lanes
);
  for (genvar k = 0; k < SLOTS; k++) begin : g_lane
    assign lanes[k*SLOT_W +: SLOT_W] = lane_en[k] ? pkt[k*SLOT_W +: SLOT_W] : '0;
  end
endmodule

// File: rtl/vliw_ep_dispatch.sv
module vliw_ep_dispatch
  import vliw_disp_pkg::*;
#(
  parameter int SLOT_W = 32,
  parameter int PBIT   = 0,
  localparam int SLOTS = NSLOT,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(SLOTS + 1),
  localparam int PKT_W = SLOTS * SLOT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fp_valid,
  input  logic [PKT_W-1:0] fp_data,
  output logic             fp_ready,
  input  logic             stall,
  output logic [SLOTS-1:0] ep_lane_valid,
  output logic [PKT_W-1:0] ep_lane_insn,
  output logic [IDX_W-1:0] ep_first_slot,
  output logic             fp_done,
  output logic [CNT_W-1:0] fp_cycles
);
  logic [PKT_W-1:0] pkt_q;
  logic             busy_q;
  logic [IDX_W-1:0] cur_q;
  logic [CNT_W-1:0] cnt_q;

  logic [SLOTS-1:0] chain;
  logic [SLOTS-1:0] grp_mask;
  logic             grp_last;
  logic [IDX_W-1:0] grp_next;

  // named internal events
  logic issue_fire;
  logic accept;

  for (genvar k = 0; k < SLOTS; k++) begin : g_chain
    assign chain[k] = pkt_q[k*SLOT_W + PBIT];
  end

  vliw_ep_scan #(.SLOTS(SLOTS)) u_scan (
    .chain      (chain),
    .start      (cur_q),
    .mask       (grp_mask),
    .last_grp   (grp_last),
    .next_start (grp_next)
  );

  assign issue_fire    = busy_q && !stall;
  assign fp_ready      = !busy_q || (issue_fire && grp_last);
  assign accept        = fp_valid && fp_ready;
  assign ep_lane_valid = issue_fire ? grp_mask : '0;
  assign ep_first_slot = cur_q;
  assign fp_done       = issue_fire && grp_last;
  assign fp_cycles     = cnt_q + CNT_W'(1);

  vliw_ep_lanes #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_lanes (
    .pkt     (pkt_q),
    .lane_en (ep_lane_valid),
    .lanes   (ep_lane_insn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_q  <= '0;
      busy_q <= 1'b0;
      cur_q  <= '0;
      cnt_q  <= '0;
    end else if (accept) begin
      pkt_q  <= fp_data;
      busy_q <= 1'b1;
      cur_q  <= '0;
      cnt_q  <= '0;
    end else if (issue_fire) begin
      if (grp_last) begin
        busy_q <= 1'b0;
      end else begin
        cur_q <= grp_next;
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/vliw_ep_dispatch_chk.sv
module vliw_ep_dispatch_chk #(
  parameter int SLOTS = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             fp_valid,
  input logic             fp_ready,
  input logic             stall,
  input logic [SLOTS-1:0] ep_lane_valid,
  input logic [IDX_W-1:0] ep_first_slot,
  input logic             fp_done,
  input logic [CNT_W-1:0] fp_cycles,
  input logic             busy
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (ep_lane_valid == '0 && fp_ready && !fp_done));

  assert_take_from_slot0_R2: assert property (@(posedge clk) disable iff (rst)
    (fp_valid && fp_ready) |=> (busy && ep_first_slot == '0));

  assert_group_leads_R3: assert property (@(posedge clk) disable iff (rst)
    (ep_lane_valid != '0) |-> (ep_lane_valid[ep_first_slot] &&
      (ep_first_slot == '0 || !ep_lane_valid[ep_first_slot - 1'b1])));

  assert_ready_low_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && !fp_done) |-> !fp_ready);

  assert_stall_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    stall |-> (ep_lane_valid == '0 && !fp_done));

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (stall && busy) |=> (busy && $stable(ep_first_slot)));

  assert_done_last_R10: assert property (@(posedge clk) disable iff (rst)
    fp_done |-> (ep_lane_valid[SLOTS-1] && fp_ready &&
                 fp_cycles != '0 && int'(fp_cycles) <= SLOTS));
endmodule

bind vliw_ep_dispatch vliw_ep_dispatch_chk #(
  .SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .fp_valid      (fp_valid),
  .fp_ready      (fp_ready),
  .stall         (stall),
  .ep_lane_valid (ep_lane_valid),
  .ep_first_slot (ep_first_slot),
  .fp_done       (fp_done),
  .fp_cycles     (fp_cycles),
  .busy          (busy_q)
);

// File: tb/vliw_ep_dispatch_tb.sv
`timescale 1ns/1ps
module vliw_ep_dispatch_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         fp_valid = 1'b0;
  logic [255:0] fp_data = '0;
  logic         fp_ready;
  logic         stall = 1'b0;
  logic [7:0]   ep_lane_valid;
  logic [255:0] ep_lane_insn;
  logic [2:0]   ep_first_slot;
  logic         fp_done;
  logic [3:0]   fp_cycles;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  vliw_ep_dispatch u_dut (
    .clk(clk), .rst(rst), .fp_valid(fp_valid), .fp_data(fp_data),
    .fp_ready(fp_ready), .stall(stall), .ep_lane_valid(ep_lane_valid),
    .ep_lane_insn(ep_lane_insn), .ep_first_slot(ep_first_slot),
    .fp_done(fp_done), .fp_cycles(fp_cycles)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // last slot of the group starting at s, restated as a forward walk
  function automatic int grp_end(input logic [255:0] d, input int s);
    int e = s;
    while (e < 7 && d[e*32]) e++;
    return e;
  endfunction

  function automatic int exp_groups(input logic [255:0] d);
    int c = 1;
    for (int k = 0; k < 7; k++) if (!d[k*32]) c++;
    return c;
  endfunction

  function automatic logic [255:0] make_pkt(input logic [7:0] bits);
    logic [255:0] d;
    for (int k = 0; k < 8; k++) begin
      d[k*32 +: 32] = {$urandom} & 32'hFFFF_FFFE;
      d[k*32]       = bits[k];
    end
    return d;
  endfunction

  task automatic present(input logic [255:0] d);
    @(negedge clk);
    fp_valid = 1'b1; fp_data = d; stall = 1'b0;
    #1;
    check(fp_ready, "R2", "ready when idle", 256'(fp_ready), 256'd1);
    check(ep_lane_valid == 8'h0, "R2", "no lanes when idle", 256'(ep_lane_valid), 256'd0);
  endtask

  task automatic issue(input logic [255:0] d, input int pct, input string rtag,
                       input bit chain, input logic [255:0] nd);
    int s = 0;
    int n = 0;
    bit fin = 0;
    int e;
    logic [7:0] m;
    logic [255:0] ins;
    while (!fin) begin
      @(negedge clk);
      fp_valid = 1'b0;
      stall = (($urandom % 100) < pct);
      #1;
      if (stall) begin
        check(ep_lane_valid == 8'h0, "R9", "lanes during stall", 256'(ep_lane_valid), 256'd0);
        check(!fp_ready, "R9", "ready during stall", 256'(fp_ready), 256'd0);
        check(ep_first_slot == 3'(s), "R9", "slot held", 256'(ep_first_slot), 256'(s));
      end else begin
        e = grp_end(d, s);
        m = '0; ins = '0;
        for (int k = s; k <= e; k++) begin
          m[k] = 1'b1;
          ins[k*32 +: 32] = d[k*32 +: 32];
        end
        n++;
        check(ep_lane_valid == m, rtag, "lane mask", 256'(ep_lane_valid), 256'(m));
        check(ep_first_slot == 3'(s), "R4", "first slot", 256'(ep_first_slot), 256'(s));
        check(ep_lane_insn == ins, "R6", "lane data", ep_lane_insn, ins);
        check(fp_ready == (e == 7), "R8", "ready", 256'(fp_ready), 256'(e == 7));
        check(fp_done == (e == 7), "R10", "done", 256'(fp_done), 256'(e == 7));
        if (e == 7) begin
          check(int'(fp_cycles) == n, "R10", "cycle count", 256'(fp_cycles), 256'(n));
          check(n == exp_groups(d), "R7", "groups", 256'(n), 256'(exp_groups(d)));
          fin = 1;
          if (chain) begin fp_valid = 1'b1; fp_data = nd; end
        end
        s = e + 1;
      end
    end
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [255:0] a, b;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(ep_lane_valid == 8'h0, "R1", "lanes after reset", 256'(ep_lane_valid), 256'd0);
    check(fp_ready, "R1", "ready after reset", 256'(fp_ready), 256'd1);
    check(!fp_done, "R1", "done after reset", 256'(fp_done), 256'd0);

    // R7 fully serial and fully parallel
    a = make_pkt(8'h00);
    present(a); issue(a, 0, "R3", 0, '0);
    a = make_pkt(8'hFF);
    present(a); issue(a, 0, "R3", 0, '0);

    // R5 slot 7 chain bit ignored; next packet starts fresh, back to back
    a = make_pkt(8'h80);
    b = make_pkt(8'hFF);
    present(a); issue(a, 0, "R5", 1, b); issue(b, 0, "R5", 0, '0);

    // R8 back-to-back chain of mixed patterns with stalls (R9)
    a = make_pkt(8'h55);
    b = make_pkt(8'h3C);
    present(a); issue(a, 30, "R3", 1, b); issue(b, 30, "R3", 0, '0);

    // R11 reset mid-packet
    a = make_pkt(8'h00);
    present(a);
    @(negedge clk); fp_valid = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1;
    check(ep_lane_valid == 8'h0, "R11", "lanes after abort", 256'(ep_lane_valid), 256'd0);
    check(fp_ready, "R11", "ready after abort", 256'(fp_ready), 256'd1);
    a = make_pkt(8'h0F);
    present(a); issue(a, 0, "R11", 0, '0);

    // random packets, some chained back to back
    b = make_pkt(8'($urandom));
    present(b);
    for (int i = 0; i < 40; i++) begin
      a = b;
      b = make_pkt(8'($urandom));
      issue(a, 25, "R3", (i % 3) != 0, b);
      if ((i % 3) == 0) present(b);
    end
    issue(b, 25, "R3", 0, '0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule